// File: doc/BRIEF.md
# Sixteen-Operation Datapath ALU

This is a purely combinational 16-bit arithmetic and logic unit for a small processor with eight general registers. Each cycle the surrounding control logic supplies a 4-bit operation code. It also supplies three selectors, and the unit uses them to choose its first operand, its second operand and its carry input. The candidate operand values arrive as plain ports: two register read values, the memory read data, an immediate and the program counter. The unit returns a 16-bit result, together with the next values of the zero and carry flags. The flag registers themselves live outside the unit.

The sixteen operations are split into two halves. The lower eight cover add, subtract, multiply, unsigned divide, the three bitwise logic operations and a pass-through of the first operand. The upper eight are shifts. There are four left shifts and four right shifts, and each one differs only in how it fills the vacated bit positions. The shift amount is taken from the second operand.

Negate and bitwise NOT need no opcodes of their own. Both are subtractions from a zero immediate. A carry input of zero gives the two's complement, and a carry input of one gives the one's complement.

Top module: `alu16_core`

## Requirements
- R1: The first-operand selector `src_a_sel` picks the operand as follows: 0 gives `rs_a`, 1 gives `mem_data`, 2 gives `imm_val` and 3 gives `pc_val`.
- R2: The second-operand selector `src_b_sel` picks the operand as follows: 0 gives `rs_b`, 1 gives the bitwise inverse of `rs_b`, 2 gives `pc_val`, and the reserved code 3 gives zero.
- R3: The carry-input selector `cin_sel` picks the carry input as follows: 0 gives constant 0, 1 gives constant 1, 2 gives `flag_c`, and 3 gives the inverse of `flag_c`.
- R4: Opcode 0 (add) returns the low 16 bits of A+B+cin. The next carry is bit 16 of that sum.
- R5: Opcode 1 (subtract) returns A-B-cin modulo 2^16, and the next carry is the borrow out. With A an immediate of 0, a carry input of 0 yields the negation of B and a carry input of 1 yields the bitwise NOT of B.
- R6: Opcode 2 (multiply) returns the low 16 bits of the unsigned product. The next carry is 1 exactly when the upper 16 bits of the product are nonzero.
- R7: Opcode 3 (divide) returns the unsigned quotient A/B with carry 0. When B is zero the result is 16'hFFFF and the carry is 1.
- R8: Opcodes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and A unchanged respectively. All four give a next carry of 0 regardless of the carry input.
- R9: Opcodes 8 to 11 shift A left by B. Bits [1:0] of the opcode select the fill for the vacated low bits: 00 fills with zeros, 01 fills with ones, 10 fills with copies of A[0], and 11 rotates. The next carry is 0 for every shift.
- R10: Opcodes 12 to 15 shift A right by B and use the same fill selection as R9. In this direction the copy fill replicates A[15].
- R11: For the non-rotating shifts, an amount of 16 or more makes every result bit equal to the fill bit. A rotate uses the amount modulo 16, and an amount of 0 returns A unchanged.
- R12: The next zero flag is 1 exactly when the 16-bit result is zero, for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select (see R4 to R10) |
| src_a_sel | input | 2 | First-operand source select |
| src_b_sel | input | 2 | Second-operand source select |
| cin_sel | input | 2 | Carry-input source select |
| flag_c | input | 1 | Current carry flag |
| rs_a | input | 16 | First register read value |
| rs_b | input | 16 | Second register read value |
| mem_data | input | 16 | Memory read data |
| imm_val | input | 16 | Immediate value |
| pc_val | input | 16 | Program counter value |
| alu_result | output | 16 | Operation result |
| flag_z_next | output | 1 | Next zero flag |
| flag_c_next | output | 1 | Next carry flag |

## Verification
The bench aims at the points where a shifter is most easily wrong.

- **Amounts of exactly 0, 15, 16 and far above 16.** A shifter that wraps the amount instead of saturating would return a partially shifted word where a full fill is expected.
- **Rotate by 16.** A rotate that mishandles this amount would come back as all zeros instead of unchanged.
- **Copy fill with an end bit of each polarity, in both directions.** A fill that copies from the wrong end shows up here.

Arithmetic is checked at its carry and borrow edges, and divide by zero is driven through the reserved second-operand code. The negate and NOT sequences pin down the sense of the carry input in subtraction: inverting it would swap the two results.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W  = 16;
    localparam int SHAMT_W = $clog2(DATA_W);

    typedef enum logic [3:0] {
        OP_ADD     = 4'd0,
        OP_SUB     = 4'd1,
        OP_MUL     = 4'd2,
        OP_DIV     = 4'd3,
        OP_AND     = 4'd4,
        OP_OR      = 4'd5,
        OP_XOR     = 4'd6,
        OP_PASS    = 4'd7,
        OP_SL_ZERO = 4'd8,
        OP_SL_ONE  = 4'd9,
        OP_SL_EDGE = 4'd10,
        OP_SL_ROT  = 4'd11,
        OP_SR_ZERO = 4'd12,
        OP_SR_ONE  = 4'd13,
        OP_SR_EDGE = 4'd14,
        OP_SR_ROT  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_EDGE = 2'd2,
        FILL_ROT  = 2'd3
    } fill_e;

    typedef enum logic [1:0] {
        ASRC_REG = 2'd0,
        ASRC_MEM = 2'd1,
        ASRC_IMM = 2'd2,
        ASRC_PC  = 2'd3
    } asrc_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_INV  = 2'd1,
        BSRC_PC   = 2'd2,
        BSRC_RSVD = 2'd3
    } bsrc_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2,
        CIN_NFLAG = 2'd3
    } cin_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
    } alu_res_t;

    function automatic logic pick_cin(cin_e sel, logic flag);
        logic c;
        case (sel)
            CIN_ZERO:  c = 1'b0;
            CIN_ONE:   c = 1'b1;
            CIN_FLAG:  c = flag;
            default:   c = ~flag;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu16_operand.sv
module alu16_operand
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [1:0]   a_sel,
    input  logic [1:0]   b_sel,
    input  logic [1:0]   c_sel,
    input  logic         flag_c,
    input  logic [W-1:0] rs_a,
    input  logic [W-1:0] rs_b,
    input  logic [W-1:0] mem_data,
    input  logic [W-1:0] imm_val,
    input  logic [W-1:0] pc_val,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b,
    output logic         cin
);

    always_comb begin
        case (asrc_e'(a_sel))
            ASRC_REG: op_a = rs_a;
            ASRC_MEM: op_a = mem_data;
            ASRC_IMM: op_a = imm_val;
            default:  op_a = pc_val;
        endcase
    end

    always_comb begin
        case (bsrc_e'(b_sel))
            BSRC_REG: op_b = rs_b;
            BSRC_INV: op_b = ~rs_b;
            BSRC_PC:  op_b = pc_val;
            default:  op_b = '0;
        endcase
    end

    assign cin = pick_cin(cin_e'(c_sel), flag_c);

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [2:0]   op_lo,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         carry
);

    localparam int PW = 2 * W;

    logic [W:0]    sum_ext;
    logic [W:0]    dif_ext;
    logic [PW-1:0] prod;
    logic [W-1:0]  quot;
    logic          div_zero;

    always_comb begin
        sum_ext  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, cin};
        dif_ext  = {1'b0, op_a} - {1'b0, op_b} - {{W{1'b0}}, cin};
        prod     = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
        div_zero = (op_b == '0);
        quot     = div_zero ? '1 : (op_a / op_b);
    end

    always_comb begin
        carry = 1'b0;
        case (op_lo)
            3'd0: begin res = sum_ext[W-1:0]; carry = sum_ext[W]; end
            3'd1: begin res = dif_ext[W-1:0]; carry = dif_ext[W]; end
            3'd2: begin res = prod[W-1:0];    carry = |prod[PW-1:W]; end
            3'd3: begin res = quot;           carry = div_zero; end
            3'd4: res = op_a & op_b;
            3'd5: res = op_a | op_b;
            3'd6: res = op_a ^ op_b;
            default: res = op_a;
        endcase
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int W    = 16,
    parameter bit LEFT = 1'b1
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] amount,
    input  logic [1:0]   fill,
    output logic [W-1:0] res
);

    localparam int SW = $clog2(W);
    localparam logic [SW:0] W_L = SW'(0) + (SW+1)'(W);

    logic          sat;
    logic [SW-1:0] n;
    logic          edge_bit;
    logic          fill_bit;
    logic [W-1:0]  moved;
    logic [W-1:0]  vacated;
    logic [W-1:0]  rotated;

    assign sat = |amount[W-1:SW];
    assign n   = amount[SW-1:0];

    generate
        if (LEFT) begin : g_left
            assign edge_bit = op_a[0];
            assign moved    = sat ? '0 : (op_a << n);
            assign vacated  = sat ? '1 : ~({W{1'b1}} << n);
            assign rotated  = (op_a << n) | (op_a >> (W_L - {1'b0, n}));
        end else begin : g_right
            assign edge_bit = op_a[W-1];
            assign moved    = sat ? '0 : (op_a >> n);
            assign vacated  = sat ? '1 : ~({W{1'b1}} >> n);
            assign rotated  = (op_a >> n) | (op_a << (W_L - {1'b0, n}));
        end
    endgenerate

    always_comb begin
        case (fill)
            2'd0:    fill_bit = 1'b0;
            2'd1:    fill_bit = 1'b1;
            default: fill_bit = edge_bit;
        endcase
        if (fill == 2'd3) res = rotated;
        else              res = (moved & ~vacated) | ({W{fill_bit}} & vacated);
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
(
    input  logic [3:0]        op_code,
    input  logic [1:0]        src_a_sel,
    input  logic [1:0]        src_b_sel,
    input  logic [1:0]        cin_sel,
    input  logic              flag_c,
    input  logic [DATA_W-1:0] rs_a,
    input  logic [DATA_W-1:0] rs_b,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] imm_val,
    input  logic [DATA_W-1:0] pc_val,
    output logic [DATA_W-1:0] alu_result,
    output logic              flag_z_next,
    output logic              flag_c_next
);

    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic              cin;
    alu_res_t          arith_out;
    alu_res_t          final_out;
    logic [DATA_W-1:0] shl_res;
    logic [DATA_W-1:0] shr_res;

    alu16_operand #(.W(DATA_W)) u_operand (
        .a_sel    (src_a_sel),
        .b_sel    (src_b_sel),
        .c_sel    (cin_sel),
        .flag_c   (flag_c),
        .rs_a     (rs_a),
        .rs_b     (rs_b),
        .mem_data (mem_data),
        .imm_val  (imm_val),
        .pc_val   (pc_val),
        .op_a     (op_a),
        .op_b     (op_b),
        .cin      (cin)
    );

    alu16_arith #(.W(DATA_W)) u_arith (
        .op_lo (op_code[2:0]),
        .op_a  (op_a),
        .op_b  (op_b),
        .cin   (cin),
        .res   (arith_out.value),
        .carry (arith_out.carry)
    );

    alu16_shift #(.W(DATA_W), .LEFT(1'b1)) u_shl (
        .op_a   (op_a),
        .amount (op_b),
        .fill   (op_code[1:0]),
        .res    (shl_res)
    );

    alu16_shift #(.W(DATA_W), .LEFT(1'b0)) u_shr (
        .op_a   (op_a),
        .amount (op_b),
        .fill   (op_code[1:0]),
        .res    (shr_res)
    );

    always_comb begin
        if (op_code[3]) begin
            final_out.value = op_code[2] ? shr_res : shl_res;
            final_out.carry = 1'b0;
        end else begin
            final_out = arith_out;
        end
    end

    assign alu_result  = final_out.value;
    assign flag_c_next = final_out.carry;
    assign flag_z_next = (final_out.value == '0);

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
    import alu16_pkg::*;
(
    input logic [3:0]        op_code,
    input logic [1:0]        src_a_sel,
    input logic [1:0]        src_b_sel,
    input logic [1:0]        cin_sel,
    input logic [DATA_W-1:0] mem_data,
    input logic [DATA_W-1:0] imm_val,
    input logic [DATA_W-1:0] alu_result,
    input logic              flag_z_next,
    input logic              flag_c_next
);

    always_comb begin
        // R12: zero flag tracks the result
        p_zero_match_r12: assert (flag_z_next == (alu_result == '0))
            else $error("zero flag disagrees with result");

        // R7: division by the reserved zero operand
        if (op_code == 4'd3 && src_b_sel == 2'd3) begin
            p_div_zero_r7: assert (alu_result == '1 && flag_c_next)
                else $error("divide by zero not saturated");
        end

        // R8: logic and pass never produce a carry
        if (op_code[3:2] == 2'b01) begin
            p_logic_nocarry_r8: assert (!flag_c_next)
                else $error("logic op produced carry");
        end

        // R8 with R1: pass of memory data
        if (op_code == 4'd7 && src_a_sel == 2'd1) begin
            p_pass_mem_r8: assert (alu_result == mem_data)
                else $error("pass did not forward memory data");
        end

        // R9: shifts never produce a carry
        if (op_code[3]) begin
            p_shift_nocarry_r9: assert (!flag_c_next)
                else $error("shift produced carry");
        end

        // R2: reserved second-operand code adds nothing
        if (op_code == 4'd0 && src_a_sel == 2'd2 && src_b_sel == 2'd3 && cin_sel == 2'd0) begin
            p_bsel_rsvd_r2: assert (alu_result == imm_val && !flag_c_next)
                else $error("reserved operand select not zero");
        end
    end

endmodule

bind alu16_core alu16_core_chk u_chk (
    .op_code     (op_code),
    .src_a_sel   (src_a_sel),
    .src_b_sel   (src_b_sel),
    .cin_sel     (cin_sel),
    .mem_data    (mem_data),
    .imm_val     (imm_val),
    .alu_result  (alu_result),
    .flag_z_next (flag_z_next),
    .flag_c_next (flag_c_next)
);

// File: tb/alu16_core_tb.sv
module alu16_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code   = '0;
    logic [1:0]  src_a_sel = '0;
    logic [1:0]  src_b_sel = '0;
    logic [1:0]  cin_sel   = '0;
    logic        flag_c    = 1'b0;
    logic [15:0] rs_a = '0, rs_b = '0, mem_data = '0, imm_val = '0, pc_val = '0;
    logic [15:0] alu_result;
    logic        flag_z_next, flag_c_next;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_core u_dut (
        .op_code     (op_code),
        .src_a_sel   (src_a_sel),
        .src_b_sel   (src_b_sel),
        .cin_sel     (cin_sel),
        .flag_c      (flag_c),
        .rs_a        (rs_a),
        .rs_b        (rs_b),
        .mem_data    (mem_data),
        .imm_val     (imm_val),
        .pc_val      (pc_val),
        .alu_result  (alu_result),
        .flag_z_next (flag_z_next),
        .flag_c_next (flag_c_next)
    );

    task automatic drive(input logic [3:0] op, input logic [1:0] as, input logic [1:0] bs,
                         input logic [1:0] cs, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_code = op; src_a_sel = as; src_b_sel = bs; cin_sel = cs;
        rs_a = a; rs_b = b;
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] er, input logic ec);
        n_chk++;
        if (alu_result !== er || flag_c_next !== ec || flag_z_next !== (er == 16'h0)) begin
            n_err++;
            $display("FAIL %s: result=%h carry=%b zero=%b expected result=%h carry=%b zero=%b",
                     tag, alu_result, flag_c_next, flag_z_next, er, ec, (er == 16'h0));
        end
    endtask

    // independent bit-by-bit shift reference
    function automatic logic [15:0] ref_shift(input logic left, input logic [1:0] fill,
                                              input logic [15:0] a, input logic [15:0] amt);
        logic [15:0] r;
        logic fb;
        int src;
        fb = (fill == 2'd0) ? 1'b0 : (fill == 2'd1) ? 1'b1 : (left ? a[0] : a[15]);
        for (int i = 0; i < 16; i++) begin
            if (fill == 2'd3) begin
                src = left ? ((i - int'(amt % 16) + 16) % 16) : ((i + int'(amt % 16)) % 16);
                r[i] = a[src];
            end else if (amt >= 16) begin
                r[i] = fb;
            end else begin
                src = left ? (i - int'(amt)) : (i + int'(amt));
                r[i] = (src < 0 || src > 15) ? fb : a[src];
            end
        end
        return r;
    endfunction

    task automatic t_reset_state;
        @(negedge clk); #1;
        chk("R12 idle inputs give zero", 16'h0000, 1'b0);
    endtask

    task automatic t_a_select;
        mem_data = 16'hBEEF; imm_val = 16'h1357; pc_val = 16'h4000;
        drive(4'd7, 2'd0, 2'd0, 2'd0, 16'hA5A5, 16'h0);  chk("R1 A=reg", 16'hA5A5, 1'b0);
        drive(4'd7, 2'd1, 2'd0, 2'd0, 16'hA5A5, 16'h0);  chk("R1 A=mem", 16'hBEEF, 1'b0);
        drive(4'd7, 2'd2, 2'd0, 2'd0, 16'hA5A5, 16'h0);  chk("R1 A=imm", 16'h1357, 1'b0);
        drive(4'd7, 2'd3, 2'd0, 2'd0, 16'hA5A5, 16'h0);  chk("R1 A=pc", 16'h4000, 1'b0);
    endtask

    task automatic t_b_select;
        imm_val = 16'h0000; pc_val = 16'h4000;
        drive(4'd0, 2'd2, 2'd0, 2'd0, 16'h0, 16'h00FF);  chk("R2 B=reg", 16'h00FF, 1'b0);
        drive(4'd0, 2'd2, 2'd1, 2'd0, 16'h0, 16'h00FF);  chk("R2 B=~reg", 16'hFF00, 1'b0);
        drive(4'd0, 2'd2, 2'd2, 2'd0, 16'h0, 16'h00FF);  chk("R2 B=pc", 16'h4000, 1'b0);
        drive(4'd0, 2'd2, 2'd3, 2'd0, 16'h0, 16'h00FF);  chk("R2 B reserved is zero", 16'h0000, 1'b0);
    endtask

    task automatic t_cin_select;
        flag_c = 1'b1;
        drive(4'd0, 2'd0, 2'd0, 2'd0, 16'h0, 16'h0);  chk("R3 cin const0", 16'h0000, 1'b0);
        drive(4'd0, 2'd0, 2'd0, 2'd1, 16'h0, 16'h0);  chk("R3 cin const1", 16'h0001, 1'b0);
        drive(4'd0, 2'd0, 2'd0, 2'd2, 16'h0, 16'h0);  chk("R3 cin flag=1", 16'h0001, 1'b0);
        drive(4'd0, 2'd0, 2'd0, 2'd3, 16'h0, 16'h0);  chk("R3 cin ~flag=1", 16'h0000, 1'b0);
        flag_c = 1'b0;
        drive(4'd0, 2'd0, 2'd0, 2'd3, 16'h0, 16'h0);  chk("R3 cin ~flag=0", 16'h0001, 1'b0);
    endtask

    task automatic t_add;
        drive(4'd0, 2'd0, 2'd0, 2'd0, 16'hFFFF, 16'h0001);  chk("R4 add wrap carry", 16'h0000, 1'b1);
        drive(4'd0, 2'd0, 2'd0, 2'd1, 16'h1234, 16'h1111);  chk("R4 add with cin", 16'h2346, 1'b0);
        drive(4'd0, 2'd0, 2'd0, 2'd1, 16'hFFFF, 16'h0000);  chk("R4 cin alone carries", 16'h0000, 1'b1);
    endtask

    task automatic t_sub;
        imm_val = 16'h0000;
        drive(4'd1, 2'd0, 2'd0, 2'd0, 16'd5, 16'd7);  chk("R5 sub borrow", 16'hFFFE, 1'b1);
        drive(4'd1, 2'd0, 2'd0, 2'd0, 16'd7, 16'd5);  chk("R5 sub no borrow", 16'h0002, 1'b0);
        drive(4'd1, 2'd0, 2'd0, 2'd1, 16'd7, 16'd5);  chk("R5 sub minus cin", 16'h0001, 1'b0);
        drive(4'd1, 2'd2, 2'd0, 2'd0, 16'h0, 16'd3);  chk("R5 negate", 16'hFFFD, 1'b1);
        drive(4'd1, 2'd2, 2'd0, 2'd1, 16'h0, 16'd3);  chk("R5 bitwise not", 16'hFFFC, 1'b1);
        drive(4'd1, 2'd2, 2'd0, 2'd0, 16'h0, 16'd0);  chk("R5 negate zero", 16'h0000, 1'b0);
    endtask

    task automatic t_mul;
        drive(4'd2, 2'd0, 2'd0, 2'd0, 16'd300, 16'd7);    chk("R6 mul small", 16'h0834, 1'b0);
        drive(4'd2, 2'd0, 2'd0, 2'd0, 16'h0100, 16'h0100); chk("R6 mul overflow", 16'h0000, 1'b1);
        drive(4'd2, 2'd0, 2'd0, 2'd0, 16'hFFFF, 16'h0002); chk("R6 mul high part", 16'hFFFE, 1'b1);
    endtask

    task automatic t_div;
        drive(4'd3, 2'd0, 2'd0, 2'd0, 16'd1000, 16'd7);    chk("R7 div", 16'h008E, 1'b0);
        drive(4'd3, 2'd0, 2'd0, 2'd0, 16'hFFFF, 16'h0100); chk("R7 div unsigned", 16'h00FF, 1'b0);
        drive(4'd3, 2'd0, 2'd3, 2'd0, 16'd1234, 16'd9);    chk("R7 div by zero", 16'hFFFF, 1'b1);
        drive(4'd3, 2'd0, 2'd0, 2'd0, 16'd3, 16'd4);       chk("R7 div to zero", 16'h0000, 1'b0);
    endtask

    task automatic t_logic;
        flag_c = 1'b1;
        drive(4'd4, 2'd0, 2'd0, 2'd2, 16'hF0F0, 16'h3C3C);  chk("R8 and", 16'h3030, 1'b0);
        drive(4'd5, 2'd0, 2'd0, 2'd2, 16'hF0F0, 16'h3C3C);  chk("R8 or", 16'hFCFC, 1'b0);
        drive(4'd6, 2'd0, 2'd0, 2'd2, 16'hF0F0, 16'h3C3C);  chk("R8 xor", 16'hCCCC, 1'b0);
        drive(4'd7, 2'd0, 2'd0, 2'd2, 16'hF0F0, 16'h3C3C);  chk("R8 pass ignores B", 16'hF0F0, 1'b0);
        drive(4'd6, 2'd0, 2'd0, 2'd2, 16'h5555, 16'h5555);  chk("R8 xor self", 16'h0000, 1'b0);
        flag_c = 1'b0;
    endtask

    task automatic t_shift_left;
        flag_c = 1'b1;
        drive(4'd8,  2'd0, 2'd0, 2'd2, 16'h8421, 16'd4);  chk("R9 shl zero", 16'h4210, 1'b0);
        drive(4'd9,  2'd0, 2'd0, 2'd2, 16'h8421, 16'd4);  chk("R9 shl one", 16'h421F, 1'b0);
        drive(4'd10, 2'd0, 2'd0, 2'd2, 16'h8421, 16'd4);  chk("R9 shl edge bit1", 16'h421F, 1'b0);
        drive(4'd10, 2'd0, 2'd0, 2'd2, 16'h8420, 16'd3);  chk("R9 shl edge bit0", 16'h2100, 1'b0);
        drive(4'd11, 2'd0, 2'd0, 2'd2, 16'h8421, 16'd4);  chk("R9 shl rotate", 16'h4218, 1'b0);
        drive(4'd8,  2'd0, 2'd0, 2'd2, 16'h8001, 16'd15); chk("R9 shl by 15", 16'h8000, 1'b0);
        flag_c = 1'b0;
    endtask

    task automatic t_shift_right;
        drive(4'd12, 2'd0, 2'd0, 2'd0, 16'h8421, 16'd4);  chk("R10 shr zero", 16'h0842, 1'b0);
        drive(4'd13, 2'd0, 2'd0, 2'd0, 16'h8421, 16'd4);  chk("R10 shr one", 16'hF842, 1'b0);
        drive(4'd14, 2'd0, 2'd0, 2'd0, 16'h8421, 16'd4);  chk("R10 shr edge bit1", 16'hF842, 1'b0);
        drive(4'd14, 2'd0, 2'd0, 2'd0, 16'h4421, 16'd3);  chk("R10 shr edge bit0", 16'h0884, 1'b0);
        drive(4'd15, 2'd0, 2'd0, 2'd0, 16'h8421, 16'd4);  chk("R10 shr rotate", 16'h1842, 1'b0);
    endtask

    task automatic t_shift_limits;
        drive(4'd8,  2'd0, 2'd0, 2'd0, 16'h8421, 16'd16);  chk("R11 shl 16 zero fill", 16'h0000, 1'b0);
        drive(4'd13, 2'd0, 2'd0, 2'd0, 16'h0001, 16'd100); chk("R11 shr 100 one fill", 16'hFFFF, 1'b0);
        drive(4'd10, 2'd0, 2'd0, 2'd0, 16'h0001, 16'd20);  chk("R11 shl 20 edge fill", 16'hFFFF, 1'b0);
        drive(4'd14, 2'd0, 2'd0, 2'd0, 16'h7FFF, 16'hFFFF); chk("R11 shr max edge fill", 16'h0000, 1'b0);
        drive(4'd11, 2'd0, 2'd0, 2'd0, 16'h8421, 16'd20);  chk("R11 rotate mod 16", 16'h4218, 1'b0);
        drive(4'd15, 2'd0, 2'd0, 2'd0, 16'h8421, 16'd16);  chk("R11 rotate by 16", 16'h8421, 1'b0);
        drive(4'd8,  2'd0, 2'd0, 2'd0, 16'h8421, 16'd0);   chk("R11 shift by 0", 16'h8421, 1'b0);
    endtask

    task automatic t_shift_sweep;
        logic [15:0] pat;
        for (int op = 8; op < 16; op++) begin
            for (int amt = 0; amt < 18; amt++) begin
                pat = 16'hB38D ^ 16'(amt * 16'h1F01);
                drive(4'(op), 2'd0, 2'd0, 2'd0, pat, 16'(amt));
                chk(op < 12 ? "R9 shl sweep" : "R10 shr sweep",
                    ref_shift(op < 12, 2'(op), pat, 16'(amt)), 1'b0);
            end
        end
    endtask

    task automatic finish_run;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_a_select();
        t_b_select();
        t_cin_select();
        t_add();
        t_sub();
        t_mul();
        t_div();
        t_logic();
        t_shift_left();
        t_shift_right();
        t_shift_limits();
        t_shift_sweep();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

endmodule